// File: doc/BRIEF.md
# UART Host Register Bank

This block is the host-facing register file of a serial port controller. A host reaches eight byte-wide locations through a 3-bit offset, a read strobe, a write strobe and an 8-bit write bus. The block holds the configuration state (line format, modem control, interrupt enables, a scratch byte and a 16-bit baud divisor) and drives it to the serializer, baud generator and interrupt logic next to it. Status bytes produced by that neighbouring logic are returned on reads.

Offsets 0 and 1 are banked. A selector bit kept in bit 7 of the line-format register chooses between the data path and interrupt enables on one side, and the two divisor bytes on the other. Offset 0 in the data bank and offset 2 in both banks lead to different places for reads and for writes. Data-bank accesses at offset 0 produce one-cycle strobes that push a byte into the transmit path or pop one from the receive path.

Top module: `uart_regbank`

## Requirements
- R1: After reset, interrupt enables, line format, modem control and scratch are 0, the divisor is 1, and the strobes tx_push, rx_pop and fifo_ctl_wr are low.
- R2: With bank bit (line format bit 7) at 0, a write to offset 0 raises tx_push for exactly the one cycle after the write edge, with tx_data_out holding the written byte; the divisor does not change.
- R3: With bank bit 0, a read of offset 0 returns rx_data_in in the same cycle and raises rx_pop for exactly the one cycle after the read edge.
- R4: With bank bit 0, offset 1 is the read/write interrupt-enable byte, presented on int_en.
- R5: With bank bit 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8; baud_div reflects each byte write on the next cycle; these accesses raise neither tx_push nor rx_pop and leave int_en unchanged.
- R6: In either bank, a read of offset 2 returns irq_id_in, and a write of offset 2 places the byte on fifo_ctl_out and raises fifo_ctl_wr for the one cycle after the write edge.
- R7: Offset 3 is the read/write line-format byte: bit 7 bank select, bit 6 break_en, bits 5:3 parity_mode, bit 2 stop_sel, bits 1:0 data_len.
- R8: Offset 4 is the read/write modem control byte (modem_ctl) and offset 7 is a read/write scratch byte.
- R9: A read of offset 5 returns line_stat_in unchanged (bit 0 receive data ready, bit 5 transmit holding empty) and offset 6 returns modem_stat_in; writes to offsets 5 and 6 change no stored byte and raise no strobe.
- R10: While reg_rd is low, reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 when not reading |
| rx_data_in | input | 8 | Head byte of the receive path |
| rx_pop | output | 1 | Pop pulse to the receive path |
| tx_data_out | output | 8 | Byte pushed to the transmit path |
| tx_push | output | 1 | Push pulse to the transmit path |
| irq_id_in | input | 8 | Interrupt identification byte |
| fifo_ctl_out | output | 8 | Last FIFO control byte written |
| fifo_ctl_wr | output | 1 | FIFO control write pulse |
| line_stat_in | input | 8 | Line status byte |
| modem_stat_in | input | 8 | Modem status byte |
| int_en | output | 8 | Interrupt enable byte |
| data_len | output | 2 | Character length code |
| stop_sel | output | 1 | Stop-bit count select |
| parity_mode | output | 3 | Parity mode code |
| break_en | output | 1 | Force break on the line |
| bank_sel | output | 1 | Divisor bank selected |
| modem_ctl | output | 8 | Modem control byte |
| baud_div | output | 16 | Baud divisor |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit offset and a divisor that comes out of reset at 1. With these values every offset, both banks and the full divisor are reachable by a short byte sequence, so the bench walks the bank bit in both directions and confirms that the same offset switches between the data path, the enables and the divisor bytes. A behavioural model tracks every stored byte and the expected strobes, and the outputs are compared with it on every access, including writes to the status offsets and idle cycles.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

   typedef enum logic [2:0] {
      OFS_DATA = 3'd0,
      OFS_IEN  = 3'd1,
      OFS_IID  = 3'd2,
      OFS_FMT  = 3'd3,
      OFS_MCTL = 3'd4,
      OFS_LST  = 3'd5,
      OFS_MST  = 3'd6,
      OFS_SCR  = 3'd7
   } ofs_e;

   typedef struct packed {
      logic       bank;
      logic       brk;
      logic [2:0] par;
      logic       stop;
      logic [1:0] len;
   } fmt_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              bank,
   output logic              wr_txd,
   output logic              rd_rxd,
   output logic              wr_ien,
   output logic              wr_fifo,
   output logic              wr_fmt,
   output logic              wr_mctl,
   output logic              wr_scr,
   output logic              wr_ro,
   output logic [1:0]        wr_div
);
   localparam int NUM_OFS = 1 << ADDR_W;

   logic [NUM_OFS-1:0] wr_sel;
   logic [NUM_OFS-1:0] rd_sel;

   generate
      for (genvar i = 0; i < NUM_OFS; i++) begin : g_sel
         assign wr_sel[i] = wr && (addr == ADDR_W'(i));
         assign rd_sel[i] = rd && (addr == ADDR_W'(i));
      end
   endgenerate

   assign wr_txd  = wr_sel[OFS_DATA] && !bank;
   assign rd_rxd  = rd_sel[OFS_DATA] && !bank;
   assign wr_ien  = wr_sel[OFS_IEN]  && !bank;
   assign wr_div  = {wr_sel[OFS_IEN] && bank, wr_sel[OFS_DATA] && bank};
   assign wr_fifo = wr_sel[OFS_IID];
   assign wr_fmt  = wr_sel[OFS_FMT];
   assign wr_mctl = wr_sel[OFS_MCTL];
   assign wr_scr  = wr_sel[OFS_SCR];
   assign wr_ro   = wr_sel[OFS_LST] || wr_sel[OFS_MST];

   logic unused_rd;
   assign unused_rd = ^rd_sel[NUM_OFS-1:1];

endmodule

// File: rtl/uart_rb_store.sv
module uart_rb_store
   import uart_rb_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int unsigned DIV_RESET = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                wr_ien,
   input  logic                wr_fmt,
   input  logic                wr_mctl,
   input  logic                wr_scr,
   input  logic                wr_ro,
   input  logic [1:0]          wr_div,
   output logic [DATA_W-1:0]   ien_q,
   output fmt_t                fmt_q,
   output logic [DATA_W-1:0]   mctl_q,
   output logic [DATA_W-1:0]   scr_q,
   output logic [2*DATA_W-1:0] div_q
);
   localparam int DIV_W     = 2 * DATA_W;
   localparam int DIV_BYTES = DIV_W / DATA_W;
   localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= '0;
         fmt_q  <= '0;
         mctl_q <= '0;
         scr_q  <= '0;
      end else begin
         if (wr_ien)  ien_q  <= wdata;
         if (wr_fmt)  fmt_q  <= fmt_t'(wdata);
         if (wr_mctl) mctl_q <= wdata;
         if (wr_scr)  scr_q  <= wdata;
      end
   end

   generate
      for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
         always_ff @(posedge clk) begin
            if (!rst_n)
               div_q[b*DATA_W +: DATA_W] <= DIV_INIT[b*DATA_W +: DATA_W];
            else if (wr_div[b])
               div_q[b*DATA_W +: DATA_W] <= wdata;
         end
      end
   endgenerate

   // R5: divisor moves only on a banked byte write
   p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div == 2'b00) |=> $stable(div_q));

   // R5: interrupt enables are untouched while the divisor bank is open
   p_ien_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q.bank && !wr_fmt) |=> $stable(ien_q));

   // R9: writes to status offsets leave every stored byte as it was
   p_ro_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ro |=> ($stable(ien_q) && $stable(fmt_q) && $stable(mctl_q)
                 && $stable(scr_q) && $stable(div_q)));

endmodule

// File: rtl/uart_rb_strobe.sv
module uart_rb_strobe #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_txd,
   input  logic              rd_rxd,
   input  logic              wr_fifo,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_pop,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_push   <= 1'b0;
         rx_pop    <= 1'b0;
         fifo_wr   <= 1'b0;
         tx_data   <= '0;
         fifo_data <= '0;
      end else begin
         tx_push <= wr_txd;
         rx_pop  <= rd_rxd;
         fifo_wr <= wr_fifo;
         if (wr_txd)  tx_data   <= wdata;
         if (wr_fifo) fifo_data <= wdata;
      end
   end

   // R2: a push pulse always follows a data-bank write of offset 0
   p_tx_push_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(wr_txd));

   // R3: a pop pulse always follows a data-bank read of offset 0
   p_rx_pop_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(rd_rxd));

   // R6: the FIFO control byte changes only alongside its write pulse
   p_fifo_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_wr |-> $stable(fifo_data));

endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
   import uart_rb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [2:0]          addr,
   input  logic                rd,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic [DATA_W-1:0]   ien,
   input  logic [DATA_W-1:0]   iid,
   input  fmt_t                fmt,
   input  logic [DATA_W-1:0]   mctl,
   input  logic [DATA_W-1:0]   lst,
   input  logic [DATA_W-1:0]   mst,
   input  logic [DATA_W-1:0]   scr,
   input  logic [2*DATA_W-1:0] div,
   output logic [DATA_W-1:0]   rdata
);
   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (ofs_e'(addr))
            OFS_DATA: rdata = fmt.bank ? div[DATA_W-1:0] : rx_data;
            OFS_IEN:  rdata = fmt.bank ? div[2*DATA_W-1:DATA_W] : ien;
            OFS_IID:  rdata = iid;
            OFS_FMT:  rdata = DATA_W'(fmt);
            OFS_MCTL: rdata = mctl;
            OFS_LST:  rdata = lst;
            OFS_MST:  rdata = mst;
            OFS_SCR:  rdata = scr;
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 3,
   parameter int unsigned DIV_RESET = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   reg_addr,
   input  logic         reg_rd,
   input  logic         reg_wr,
   input  logic [7:0]   reg_wdata,
   output logic [7:0]   reg_rdata,
   input  logic [7:0]   rx_data_in,
   output logic         rx_pop,
   output logic [7:0]   tx_data_out,
   output logic         tx_push,
   input  logic [7:0]   irq_id_in,
   output logic [7:0]   fifo_ctl_out,
   output logic         fifo_ctl_wr,
   input  logic [7:0]   line_stat_in,
   input  logic [7:0]   modem_stat_in,
   output logic [7:0]   int_en,
   output logic [1:0]   data_len,
   output logic         stop_sel,
   output logic [2:0]   parity_mode,
   output logic         break_en,
   output logic         bank_sel,
   output logic [7:0]   modem_ctl,
   output logic [15:0]  baud_div
);
   localparam int DIV_W = 2 * DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_regbank: DATA_W must be 8");
      end
      if (ADDR_W != 3) begin : g_bad_addr
         $error("uart_regbank: ADDR_W must be 3");
      end
      if (DIV_RESET == 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_div
         $error("uart_regbank: DIV_RESET out of range");
      end
   endgenerate

   logic             wr_txd, rd_rxd, wr_ien, wr_fifo, wr_fmt;
   logic             wr_mctl, wr_scr, wr_ro;
   logic [1:0]       wr_div;
   logic [7:0]       ien_q, mctl_q, scr_q;
   fmt_t             fmt_q;
   logic [DIV_W-1:0] div_q;

   uart_rb_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr    (reg_addr),
      .rd      (reg_rd),
      .wr      (reg_wr),
      .bank    (fmt_q.bank),
      .wr_txd  (wr_txd),
      .rd_rxd  (rd_rxd),
      .wr_ien  (wr_ien),
      .wr_fifo (wr_fifo),
      .wr_fmt  (wr_fmt),
      .wr_mctl (wr_mctl),
      .wr_scr  (wr_scr),
      .wr_ro   (wr_ro),
      .wr_div  (wr_div)
   );

   uart_rb_store #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (reg_wdata),
      .wr_ien  (wr_ien),
      .wr_fmt  (wr_fmt),
      .wr_mctl (wr_mctl),
      .wr_scr  (wr_scr),
      .wr_ro   (wr_ro),
      .wr_div  (wr_div),
      .ien_q   (ien_q),
      .fmt_q   (fmt_q),
      .mctl_q  (mctl_q),
      .scr_q   (scr_q),
      .div_q   (div_q)
   );

   uart_rb_strobe #(.DATA_W(DATA_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdata     (reg_wdata),
      .wr_txd    (wr_txd),
      .rd_rxd    (rd_rxd),
      .wr_fifo   (wr_fifo),
      .tx_push   (tx_push),
      .tx_data   (tx_data_out),
      .rx_pop    (rx_pop),
      .fifo_wr   (fifo_ctl_wr),
      .fifo_data (fifo_ctl_out)
   );

   uart_rb_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .addr    (reg_addr),
      .rd      (reg_rd),
      .rx_data (rx_data_in),
      .ien     (ien_q),
      .iid     (irq_id_in),
      .fmt     (fmt_q),
      .mctl    (mctl_q),
      .lst     (line_stat_in),
      .mst     (modem_stat_in),
      .scr     (scr_q),
      .div     (div_q),
      .rdata   (reg_rdata)
   );

   assign int_en      = ien_q;
   assign data_len    = fmt_q.len;
   assign stop_sel    = fmt_q.stop;
   assign parity_mode = fmt_q.par;
   assign break_en    = fmt_q.brk;
   assign bank_sel    = fmt_q.bank;
   assign modem_ctl   = mctl_q;
   assign baud_div    = div_q;

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [7:0]  rx_data_in = '0;
   logic        rx_pop;
   logic [7:0]  tx_data_out;
   logic        tx_push;
   logic [7:0]  irq_id_in = '0;
   logic [7:0]  fifo_ctl_out;
   logic        fifo_ctl_wr;
   logic [7:0]  line_stat_in = '0;
   logic [7:0]  modem_stat_in = '0;
   logic [7:0]  int_en;
   logic [1:0]  data_len;
   logic        stop_sel;
   logic [2:0]  parity_mode;
   logic        break_en;
   logic        bank_sel;
   logic [7:0]  modem_ctl;
   logic [15:0] baud_div;

   always #4 clk = ~clk;

   uart_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_data_in(rx_data_in), .rx_pop(rx_pop), .tx_data_out(tx_data_out),
      .tx_push(tx_push), .irq_id_in(irq_id_in), .fifo_ctl_out(fifo_ctl_out),
      .fifo_ctl_wr(fifo_ctl_wr), .line_stat_in(line_stat_in),
      .modem_stat_in(modem_stat_in), .int_en(int_en), .data_len(data_len),
      .stop_sel(stop_sel), .parity_mode(parity_mode), .break_en(break_en),
      .bank_sel(bank_sel), .modem_ctl(modem_ctl), .baud_div(baud_div)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model state
   int m_ien = 0, m_fmt = 0, m_mctl = 0, m_scr = 0, m_div = 1;
   int m_txd = 0, m_fifo = 0;
   bit m_push = 0, m_pop = 0, m_fwr = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_read(input int a);
      bit bank = m_fmt[7];
      case (a)
         0: return bank ? (m_div & 8'hFF) : int'(rx_data_in);
         1: return bank ? ((m_div >> 8) & 8'hFF) : m_ien;
         2: return int'(irq_id_in);
         3: return m_fmt;
         4: return m_mctl;
         5: return int'(line_stat_in);
         6: return int'(modem_stat_in);
         default: return m_scr;
      endcase
   endfunction

   task automatic check_outputs(input string req);
      chk(req, "tx_push", int'(tx_push), int'(m_push));
      chk(req, "rx_pop", int'(rx_pop), int'(m_pop));
      chk(req, "fifo_ctl_wr", int'(fifo_ctl_wr), int'(m_fwr));
      chk(req, "tx_data_out", int'(tx_data_out), m_txd);
      chk(req, "fifo_ctl_out", int'(fifo_ctl_out), m_fifo);
      chk(req, "int_en", int'(int_en), m_ien);
      chk(req, "bank_sel", int'(bank_sel), (m_fmt >> 7) & 1);
      chk(req, "break_en", int'(break_en), (m_fmt >> 6) & 1);
      chk(req, "parity_mode", int'(parity_mode), (m_fmt >> 3) & 7);
      chk(req, "stop_sel", int'(stop_sel), (m_fmt >> 2) & 1);
      chk(req, "data_len", int'(data_len), m_fmt & 3);
      chk(req, "modem_ctl", int'(modem_ctl), m_mctl);
      chk(req, "baud_div", int'(baud_div), m_div);
   endtask

   task automatic op(input bit w, input bit r, input int a, input int d, input string req);
      int exp_rd;
      bit bank;
      @(negedge clk);
      reg_wr = w; reg_rd = r; reg_addr = 3'(a); reg_wdata = 8'(d);
      #1;
      exp_rd = r ? model_read(a) : 0;
      chk(r ? req : "R10", "reg_rdata", int'(reg_rdata), exp_rd);
      @(posedge clk);
      bank = m_fmt[7];
      m_push = w && a == 0 && !bank;
      m_pop  = r && a == 0 && !bank;
      m_fwr  = w && a == 2;
      if (w) begin
         case (a)
            0: if (bank) m_div = (m_div & 16'hFF00) | d; else m_txd = d;
            1: if (bank) m_div = (m_div & 16'h00FF) | (d << 8); else m_ien = d;
            2: m_fifo = d;
            3: m_fmt = d;
            4: m_mctl = d;
            7: m_scr = d;
            default: ;
         endcase
      end
      #1;
      check_outputs(req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_outputs("R1");

      // R7: line format fields
      op(1, 0, 3, 8'h03, "R7");
      op(0, 1, 3, 0, "R7");
      // R2: transmit push in data bank
      op(1, 0, 0, 8'h5A, "R2");
      op(0, 0, 0, 0, "R2");
      op(1, 0, 0, 8'hA7, "R2");
      op(1, 0, 0, 8'h3C, "R2");
      op(0, 0, 0, 0, "R2");
      // R3: receive read and pop
      rx_data_in = 8'hC3;
      op(0, 1, 0, 0, "R3");
      op(0, 0, 0, 0, "R3");
      rx_data_in = 8'h1E;
      op(0, 1, 0, 0, "R3");
      // R4: interrupt enables
      op(1, 0, 1, 8'h0F, "R4");
      op(0, 1, 1, 0, "R4");
      // R5: divisor bank
      op(1, 0, 3, 8'h80, "R5");
      op(0, 1, 0, 0, "R5");
      op(1, 0, 0, 8'h34, "R5");
      op(1, 0, 1, 8'h12, "R5");
      op(0, 1, 0, 0, "R5");
      op(0, 1, 1, 0, "R5");
      // R6: identification and FIFO control, divisor bank open
      irq_id_in = 8'hC2;
      op(1, 0, 2, 8'hC7, "R6");
      op(0, 1, 2, 0, "R6");
      // back to data bank, divisor kept
      op(1, 0, 3, 8'h3B, "R7");
      op(0, 1, 1, 0, "R4");
      op(1, 0, 2, 8'h01, "R6");
      irq_id_in = 8'h04;
      op(0, 1, 2, 0, "R6");
      op(1, 0, 3, 8'h44, "R7");
      op(0, 1, 3, 0, "R7");
      op(1, 0, 3, 8'h00, "R7");
      // R8: modem control and scratch
      op(1, 0, 4, 8'h1F, "R8");
      op(0, 1, 4, 0, "R8");
      op(1, 0, 7, 8'hA5, "R8");
      op(0, 1, 7, 0, "R8");
      // R9: status reads and ignored writes
      line_stat_in = 8'h21;
      modem_stat_in = 8'h90;
      op(0, 1, 5, 0, "R9");
      op(0, 1, 6, 0, "R9");
      op(1, 0, 5, 8'hFF, "R9");
      op(1, 0, 6, 8'hFF, "R9");
      op(0, 1, 7, 0, "R9");
      op(0, 1, 1, 0, "R9");
      op(0, 1, 3, 0, "R9");
      op(0, 1, 4, 0, "R9");
      op(1, 0, 3, 8'h80, "R9");
      op(1, 0, 5, 8'hEE, "R9");
      op(0, 1, 0, 0, "R9");
      op(0, 1, 1, 0, "R9");
      // R10: idle cycles present zero
      op(0, 0, 7, 0, "R10");
      op(0, 0, 1, 0, "R10");

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule